// File: doc/BRIEF.md
# Element-width saturating adder

This block is an integer adder for a wide datapath in which every operation picks its own element width: 8, 16, 32 or the full 64 bits. Each operation supplies two operands, a carry-in, a width code, a flag that says whether the operands are signed, and a saturation mode. The mode can be wrap-around, signed clamping or unsigned clamping. Only the low bits of each operand that fall inside the chosen width take part in the sum.

The sum is formed two bits wider than the element, so it is exact, and every overflow decision is taken against that exact value. The block returns the element result zero-extended to 64 bits. It also returns a carry-out taken at the element boundary and a four-flag condition field. Three flags compare the final result with zero, and the fourth reports overflow of the current operation only. All outputs are registered and appear one cycle after the input is accepted. A pipeline controller issues operations back to back on this block and reads the flags in the cycle after issue.

Top module: `ew_sat_adder`

## Requirements
- R1: Width code 0, 1, 2, 3 selects an element width W of 8, 16, 32, 64 bits. With saturation mode 0 (wrap), the result is (a mod 2^W) + (b mod 2^W) + carry_in, taken modulo 2^W.
- R2: carry_out equals bit W of the unsigned sum of the low W bits of both operands plus carry_in. It does not depend on op_signed or on the saturation mode.
- R3: Saturation mode 1 (signed) clamps an exact sum above 2^(W-1)-1 to that value and an exact sum below -2^(W-1) to -2^(W-1) in W-bit two's complement. The exact sum treats the operands as signed when op_signed is 1 and as unsigned otherwise.
- R4: Saturation mode 2 (unsigned) clamps an exact sum above 2^W-1 to all-ones. It clamps a negative exact sum, which can only come from signed operands, to zero.
- R5: The overflow flag, cond_flags bit 0, is 1 exactly when the exact sum lies outside the range being checked. That range is signed for mode 1, and also for mode 0 with op_signed set. Otherwise it is unsigned. The flag depends only on the current operation: an operation without overflow that follows one with overflow reports 0.
- R6: cond_flags bit 3 (less than zero), bit 2 (greater than zero) and bit 1 (equal to zero) compare the final result with zero, and exactly one of them is set. The result is read as unsigned for mode 2, and also for mode 0 with op_signed clear. Otherwise it is read as W-bit signed.
- R7: Bits of out_result at and above position W are zero.
- R8: An operation accepted at a clock edge with in_valid high is presented, with out_valid high, after the next clock edge. After an edge where in_valid is low, out_valid is low and out_result, carry_out and cond_flags keep their previous values.
- R9: Saturation mode 3 behaves exactly like mode 0.
- R10: After reset, out_valid, out_result, carry_out and cond_flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_a | input | 64 | First operand, low W bits used |
| op_b | input | 64 | Second operand, low W bits used |
| carry_in | input | 1 | Carry added into the sum |
| width_sel | input | 2 | Element width code: 0=8, 1=16, 2=32, 3=64 |
| sat_mode | input | 2 | 0 wrap, 1 signed clamp, 2 unsigned clamp, 3 as wrap |
| op_signed | input | 1 | Operands are two's complement when 1 |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 64 | Element result, zero-extended |
| carry_out | output | 1 | Carry out of bit W-1 |
| cond_flags | output | 4 | {LT, GT, EQ, SO} |

## Verification
Directed operands sit on the clamp boundaries at each width: the largest positive value plus one, the most negative value plus minus one, and all-ones plus one. These show whether saturation is decided on the exact sum or on wrapped bits, and whether it uses the selected width or the full 64 bits. Signed operands with a negative sum under unsigned clamping separate the clamp-to-zero rule from the clamp-to-all-ones rule. Operands with garbage above the element width test masking and the zero upper bits. An overflowing operation followed by a clean one exposes any sticky flag, and idle cycles with changed operands expose outputs that fail to hold. Random operations with mixed widths, modes, signedness and carries, issued back to back, then cover the combinations against a model computed at wider precision.

// File: rtl/ew_sat_pkg.sv
package ew_sat_pkg;

    typedef enum logic [1:0] {
        SAT_NONE     = 2'd0,
        SAT_SIGNED   = 2'd1,
        SAT_UNSIGNED = 2'd2,
        SAT_RSVD     = 2'd3
    } sat_mode_e;

    localparam int FLAG_LT = 3;
    localparam int FLAG_GT = 2;
    localparam int FLAG_EQ = 1;
    localparam int FLAG_SO = 0;
    localparam int FLAG_W  = 4;

endpackage

// File: rtl/ew_sum_exact.sv
module ew_sum_exact #(
    parameter int LW = 8
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  logic          cin,
    input  logic          op_signed,
    output logic [LW+1:0] exact,
    output logic          cout
);
    logic [LW+1:0] a_ext;
    logic [LW+1:0] b_ext;
    logic [LW:0]   uns_sum;

    always_comb begin
        a_ext   = op_signed ? {{2{a[LW-1]}}, a} : {2'b00, a};
        b_ext   = op_signed ? {{2{b[LW-1]}}, b} : {2'b00, b};
        exact   = a_ext + b_ext + {{(LW+1){1'b0}}, cin};
        uns_sum = {1'b0, a} + {1'b0, b} + {{LW{1'b0}}, cin};
        cout    = uns_sum[LW];
    end
endmodule

// File: rtl/ew_clamp.sv
module ew_clamp
    import ew_sat_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic [LW+1:0] exact,
    input  logic          op_signed,
    input  logic [1:0]    sat_mode,
    output logic [LW-1:0] res,
    output logic          ovf
);
    localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};
    localparam logic [LW-1:0] UMAX = {LW{1'b1}};

    logic [2:0] top3;
    logic       s_ok;
    logic       u_ok;
    logic       check_signed;
    logic       negative;

    always_comb begin
        top3         = exact[LW+1:LW-1];
        s_ok         = (top3 == 3'b000) || (top3 == 3'b111);
        u_ok         = (exact[LW+1:LW] == 2'b00);
        negative     = exact[LW+1];
        check_signed = (sat_mode == SAT_SIGNED) ||
                       ((sat_mode != SAT_UNSIGNED) && op_signed);
        ovf          = check_signed ? !s_ok : !u_ok;
        res          = exact[LW-1:0];
        if (sat_mode == SAT_SIGNED && !s_ok) begin
            res = negative ? SMIN : SMAX;
        end else if (sat_mode == SAT_UNSIGNED && !u_ok) begin
            res = negative ? '0 : UMAX;
        end
    end
endmodule

// File: rtl/ew_cond_flags.sv
module ew_cond_flags #(
    parameter int XLEN     = 64,
    parameter int ELEM_MIN = 8,
    parameter int WSEL_W   = 2
) (
    input  logic [XLEN-1:0]   result,
    input  logic [WSEL_W-1:0] width_sel,
    input  logic              uns_view,
    output logic              lt,
    output logic              gt,
    output logic              eq
);
    localparam int IDX_W = $clog2(XLEN);

    logic [IDX_W-1:0] msb_idx;
    logic             neg;

    always_comb begin
        msb_idx = IDX_W'((ELEM_MIN << width_sel) - 1);
        neg     = !uns_view && result[msb_idx];
        eq      = (result == '0);
        lt      = neg;
        gt      = !neg && !eq;
    end
endmodule

// File: rtl/ew_sat_adder.sv
module ew_sat_adder
    import ew_sat_pkg::*;
#(
    parameter int ELEM_MIN   = 8,
    parameter int NUM_WIDTHS = 4,
    parameter int XLEN       = ELEM_MIN << (NUM_WIDTHS - 1),
    parameter int WSEL_W     = $clog2(NUM_WIDTHS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    input  logic              carry_in,
    input  logic [WSEL_W-1:0] width_sel,
    input  logic [1:0]        sat_mode,
    input  logic              op_signed,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_result,
    output logic              carry_out,
    output logic [FLAG_W-1:0] cond_flags
);
    typedef struct packed {
        logic              valid;
        logic [XLEN-1:0]   result;
        logic              cout;
        logic [FLAG_W-1:0] cond;
    } out_s;

    out_s st_d;
    out_s st_q;

    logic [XLEN-1:0]       lane_res [NUM_WIDTHS];
    logic [NUM_WIDTHS-1:0] lane_cout;
    logic [NUM_WIDTHS-1:0] lane_ovf;

    for (genvar gi = 0; gi < NUM_WIDTHS; gi++) begin : g_lane
        localparam int LW = ELEM_MIN << gi;
        logic [LW+1:0] exact;
        logic [LW-1:0] res;

        ew_sum_exact #(.LW(LW)) u_sum (
            .a         (op_a[LW-1:0]),
            .b         (op_b[LW-1:0]),
            .cin       (carry_in),
            .op_signed (op_signed),
            .exact     (exact),
            .cout      (lane_cout[gi])
        );

        ew_clamp #(.LW(LW)) u_clamp (
            .exact     (exact),
            .op_signed (op_signed),
            .sat_mode  (sat_mode),
            .res       (res),
            .ovf       (lane_ovf[gi])
        );

        assign lane_res[gi] = XLEN'(res);
    end

    logic [XLEN-1:0] sel_res;
    logic            uns_view;
    logic            f_lt;
    logic            f_gt;
    logic            f_eq;

    assign sel_res  = lane_res[width_sel];
    assign uns_view = (sat_mode == SAT_UNSIGNED) ||
                      ((sat_mode != SAT_SIGNED) && !op_signed);

    ew_cond_flags #(
        .XLEN     (XLEN),
        .ELEM_MIN (ELEM_MIN),
        .WSEL_W   (WSEL_W)
    ) u_flags (
        .result    (sel_res),
        .width_sel (width_sel),
        .uns_view  (uns_view),
        .lt        (f_lt),
        .gt        (f_gt),
        .eq        (f_eq)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result           = sel_res;
            st_d.cout             = lane_cout[width_sel];
            st_d.cond             = '0;
            st_d.cond[FLAG_LT]    = f_lt;
            st_d.cond[FLAG_GT]    = f_gt;
            st_d.cond[FLAG_EQ]    = f_eq;
            st_d.cond[FLAG_SO]    = lane_ovf[width_sel];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign carry_out  = st_q.cout;
    assign cond_flags = st_q.cond;

endmodule

// File: rtl/ew_sat_adder_chk.sv
module ew_sat_adder_chk
    import ew_sat_pkg::*;
#(
    parameter int ELEM_MIN   = 8,
    parameter int NUM_WIDTHS = 4,
    parameter int XLEN       = ELEM_MIN << (NUM_WIDTHS - 1),
    parameter int WSEL_W     = $clog2(NUM_WIDTHS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [XLEN-1:0]   op_a,
    input logic [XLEN-1:0]   op_b,
    input logic              carry_in,
    input logic [WSEL_W-1:0] width_sel,
    input logic [1:0]        sat_mode,
    input logic              op_signed,
    input logic              out_valid,
    input logic [XLEN-1:0]   out_result,
    input logic              carry_out,
    input logic [FLAG_W-1:0] cond_flags
);
    logic            started_q;
    logic [XLEN-1:0] keep_q;
    logic            uns_sat_q;
    logic [XLEN-1:0] keep_now;
    int              w_now;

    always_comb begin
        w_now = ELEM_MIN << width_sel;
        if (w_now >= XLEN) begin
            keep_now = '1;
        end else begin
            keep_now = (XLEN'(1) << w_now) - XLEN'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            keep_q    <= '1;
            uns_sat_q <= 1'b0;
        end else begin
            started_q <= 1'b1;
            if (in_valid) begin
                keep_q    <= keep_now;
                uns_sat_q <= (sat_mode == SAT_UNSIGNED);
            end
        end
    end

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (out_valid == $past(in_valid)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(cond_flags) && $stable(carry_out)));

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_result & ~keep_q) == '0));

    assert_one_compare_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(cond_flags[FLAG_LT:FLAG_EQ]) == 1));

    assert_eq_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cond_flags[FLAG_EQ] == (out_result == '0)));

    assert_uns_not_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && uns_sat_q) |-> !cond_flags[FLAG_LT]);

endmodule

bind ew_sat_adder ew_sat_adder_chk #(
    .ELEM_MIN   (ELEM_MIN),
    .NUM_WIDTHS (NUM_WIDTHS),
    .XLEN       (XLEN),
    .WSEL_W     (WSEL_W)
) u_chk (.*);

// File: tb/ew_sat_adder_bench.sv
module ew_sat_adder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [1:0]  width_sel = '0;
    logic [1:0]  sat_mode = '0;
    logic        op_signed = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        carry_out;
    logic [3:0]  cond_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ew_sat_adder u_ew_sat_adder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .width_sel(width_sel), .sat_mode(sat_mode),
        .op_signed(op_signed), .out_valid(out_valid), .out_result(out_result),
        .carry_out(carry_out), .cond_flags(cond_flags)
    );

    task automatic model(input logic [63:0] a, input logic [63:0] b, input logic cin,
                         input logic [1:0] ws, input logic [1:0] sm, input logic sg,
                         output logic [63:0] res, output logic co, output logic [3:0] cf);
        int w;
        logic signed [67:0] p2w, aw, bw, ea, eb, ex, us, smax, smin, umax, r;
        logic chk_s, ovf, uns, neg, zero;
        w    = 8 << ws;
        p2w  = 68'sd1 <<< w;
        umax = p2w - 68'sd1;
        smax = (p2w >>> 1) - 68'sd1;
        smin = -(p2w >>> 1);
        aw   = {4'b0, a} & umax;
        bw   = {4'b0, b} & umax;
        ea   = (sg && aw[w-1]) ? aw - p2w : aw;
        eb   = (sg && bw[w-1]) ? bw - p2w : bw;
        ex   = ea + eb + (cin ? 68'sd1 : 68'sd0);
        us   = aw + bw + (cin ? 68'sd1 : 68'sd0);
        co   = us[w];
        chk_s = (sm == 2'd1) || (sm != 2'd2 && sg);
        ovf  = chk_s ? (ex > smax || ex < smin) : (ex > umax || ex < 68'sd0);
        r    = ex & umax;
        if (sm == 2'd1 && ovf) r = (ex < 68'sd0) ? (smin & umax) : smax;
        else if (sm == 2'd2 && ovf) r = (ex < 68'sd0) ? 68'sd0 : umax;
        res  = r[63:0];
        uns  = (sm == 2'd2) || (sm != 2'd1 && !sg);
        neg  = !uns && r[w-1];
        zero = (r == 68'sd0);
        cf   = {neg, !neg && !zero, zero, ovf};
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge (one register stage)
    task automatic op(input logic [63:0] a, input logic [63:0] b, input logic cin,
                      input logic [1:0] ws, input logic [1:0] sm, input logic sg,
                      input string tag);
        logic [63:0] er;
        logic ec;
        logic [3:0] ef;
        model(a, b, cin, ws, sm, sg, er, ec, ef);
        in_valid = 1'b1; op_a = a; op_b = b; carry_in = cin;
        width_sel = ws; sat_mode = sm; op_signed = sg;
        @(negedge clk);
        check(tag, {out_valid, out_result, carry_out, cond_flags}, {1'b1, er, ec, ef});
    endtask

    task automatic idle(input string tag);
        logic [63:0] pr;
        logic pc;
        logic [3:0] pf;
        pr = out_result; pc = carry_out; pf = cond_flags;
        in_valid = 1'b0; op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom};
        carry_in = ~carry_in; sat_mode = sat_mode + 2'd1;
        @(negedge clk);
        check(tag, {out_valid, out_result, carry_out, cond_flags}, {1'b0, pr, pc, pf});
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] ra, rb;
        void'($urandom(32'h5A17_C0DE));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", {out_valid, out_result, carry_out, cond_flags}, 70'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {out_valid, out_result, carry_out, cond_flags}, 70'd0);

        // R1 wrap at 8 bits, unsigned: 0xFF+1 -> 0, carry, overflow, EQ
        op(64'hFF, 64'h01, 1'b0, 2'd0, 2'd0, 1'b0, "R1");
        check("R1", out_result, 64'h0);
        check("R5", {60'd0, cond_flags}, 64'b0011);
        // R2 carry at bit 8 with carry-in
        op(64'h80, 64'h80, 1'b1, 2'd0, 2'd0, 1'b1, "R2");
        check("R2", {63'd0, carry_out}, 64'd1);
        check("R2", out_result, 64'h01);
        // R5 not sticky: clean op after overflow
        op(64'h01, 64'h01, 1'b0, 2'd0, 2'd0, 1'b1, "R5");
        check("R5", {63'd0, cond_flags[0]}, 64'd0);
        // R3 signed clamp at 16 bits, both directions
        op(64'h7FFF, 64'h0001, 1'b0, 2'd1, 2'd1, 1'b1, "R3");
        check("R3", out_result, 64'h7FFF);
        op(64'h8000, 64'hFFFF, 1'b0, 2'd1, 2'd1, 1'b1, "R3");
        check("R3", out_result, 64'h8000);
        check("R6", {63'd0, cond_flags[3]}, 64'd1);
        // R3 at 64 bits
        op(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 2'd3, 2'd1, 1'b1, "R3");
        check("R3", out_result, 64'h7FFF_FFFF_FFFF_FFFF);
        op(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd3, 2'd1, 1'b1, "R3");
        // R4 unsigned clamp: negative signed sum -> zero, big unsigned -> all-ones
        op(64'hFFFF_FFFF, 64'h0, 1'b0, 2'd2, 2'd2, 1'b1, "R4");
        check("R4", out_result, 64'h0);
        check("R4", {60'd0, cond_flags}, 64'b0011);
        op(64'hFFFF_FFFF, 64'h1, 1'b0, 2'd2, 2'd2, 1'b0, "R4");
        check("R4", out_result, 64'hFFFF_FFFF);
        op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd3, 2'd2, 1'b0, "R4");
        check("R4", out_result, 64'hFFFF_FFFF_FFFF_FFFF);
        // R6 unsigned view in wrap mode: 0x80 at width 8 is GT
        op(64'h7F, 64'h01, 1'b0, 2'd0, 2'd0, 1'b0, "R6");
        check("R6", {60'd0, cond_flags}, 64'b0100);
        // R7 garbage above width
        op(64'hDEAD_BEEF_CAFE_0012, 64'h1234_5678_9ABC_0034, 1'b0, 2'd0, 2'd0, 1'b0, "R7");
        check("R7", out_result, 64'h46);
        op(64'hDEAD_BEEF_7FFF_FFFF, 64'hFFFF_0000_0000_0001, 1'b0, 2'd2, 2'd1, 1'b1, "R7");
        check("R7", out_result, 64'h7FFF_FFFF);
        // R9 reserved mode acts as wrap
        op(64'h7F, 64'h01, 1'b0, 2'd0, 2'd3, 1'b1, "R9");
        check("R9", out_result, 64'h80);
        // R8 hold while idle
        idle("R8");
        idle("R8");

        for (int i = 0; i < 600; i++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (($urandom % 4) == 0) ra = ra >> ($urandom % 8);
            if (($urandom % 4) == 0) rb = ~rb;
            op(ra, rb, 1'($urandom % 2), 2'($urandom % 4), 2'($urandom % 4),
               1'($urandom % 2), "R1");
            if (($urandom % 16) == 0) idle("R8");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule